// File: doc/BRIEF.md
# Two-Digit Multiplexed Hex Display Driver

This block shows one byte as two hexadecimal characters on a seven-segment module with two digits. The digits share a single set of seven segment lines, and one select pin decides which digit is lit. The driver shows the low nibble while the select pin is 0 and the high nibble while it is 1. It swaps between them on a refresh timer derived from the system clock, so both characters appear lit all the time.

Each nibble is decoded to an active-high segment pattern for the characters 0 to 9 and A, b, C, d, E, F. The segment lines and the select pin are registered, and they change together on a single clock edge. The input byte is sampled only at that edge. A change to the input in the middle of a dwell period therefore never reaches the display early.

Two parameters set the refresh rate. `CLK_HZ` gives the clock rate and `REFRESH_HZ` gives how often each digit is refreshed, with a default of 200 per second. Each digit stays lit for `CLK_HZ/(2*REFRESH_HZ)` clock cycles. A synchronous, active-high reset blanks the display and sets the select pin to 0 until the first swap.

Top module: `twin_hex_display`

## Requirements
- R1: While reset is high, and after it until the first swap, segOut is 0 (all segments off) and digitSel is 0.
- R2: The first swap happens exactly DWELL = CLK_HZ/(2*REFRESH_HZ) clock edges after reset is released. At that edge digitSel becomes 1 and the high nibble is shown.
- R3: After the first swap, digitSel inverts every DWELL clock edges, so each digit is refreshed REFRESH_HZ times per second.
- R4: When digitSel is 0, segOut shows hexVal[3:0]. When digitSel is 1, segOut shows hexVal[7:4]. In both cases the nibble is the one sampled at the swap edge.
- R5: Segments are active high, with segment a at bit 0 through segment g at bit 6. The digits decode to 0=7'h3F, 1=7'h06, 2=7'h5B, 3=7'h4F, 4=7'h66, 5=7'h6D, 6=7'h7D, 7=7'h07, 8=7'h7F, 9=7'h6F.
- R6: The letters decode to A(10)=7'h77, b(11)=7'h7C, C(12)=7'h39, d(13)=7'h5E, E(14)=7'h79, F(15)=7'h71.
- R7: segOut and digitSel change only on a swap edge, and both change on that same edge.
- R8: A change of hexVal between swaps has no effect on segOut or digitSel until the next swap, which then shows the new value.
- R9: Asserting reset during operation returns the block to the blank state of R1 on the next clock edge and restarts the DWELL timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hexVal | input | 8 | Byte to display; low nibble on digit 0, high nibble on digit 1 |
| segOut | output | 7 | Shared segment lines, active high, a at bit 0 to g at bit 6 |
| digitSel | output | 1 | Digit select: 0 low-nibble digit, 1 high-nibble digit |

## Verification
A refresh counter that drifts shows up at the ports as a swap edge that comes early or late. The bench counts edges from reset release, so a single cycle of error is caught at the first swap. A select phase that is wrong, or a nibble mux that is wrong, makes one digit show the other nibble, and this is visible at the first swap after the fault. A decoder or sampling fault shows as a wrong pattern or as an update in the middle of a period. These are caught within one dwell period, because the outputs are read both at each swap and between swaps.

// File: rtl/twin_hex_pkg.sv
package twin_hex_pkg;

  typedef struct packed {
    logic tick;      // swap digits on this edge
    logic nextHigh;  // digit to show after the swap: 1 = high nibble
  } scanStrobe_t;

  function automatic logic [6:0] hexToSeg(input logic [3:0] nib);
    logic [6:0] s;
    case (nib)
      4'h0: s = 7'h3F;
      4'h1: s = 7'h06;
      4'h2: s = 7'h5B;
      4'h3: s = 7'h4F;
      4'h4: s = 7'h66;
      4'h5: s = 7'h6D;
      4'h6: s = 7'h7D;
      4'h7: s = 7'h07;
      4'h8: s = 7'h7F;
      4'h9: s = 7'h6F;
      4'hA: s = 7'h77;
      4'hB: s = 7'h7C;
      4'hC: s = 7'h39;
      4'hD: s = 7'h5E;
      4'hE: s = 7'h79;
      default: s = 7'h71;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/twin_hex_ctrl.sv
module twin_hex_ctrl
  import twin_hex_pkg::*;
#(
  parameter int CLK_HZ     = 25_000_000,
  parameter int REFRESH_HZ = 200
) (
  input  logic        clk,
  input  logic        rst,
  output scanStrobe_t strb
);

  localparam int DWELL = CLK_HZ / (2 * REFRESH_HZ);
  localparam int CNT_W = (DWELL > 2) ? $clog2(DWELL) : 1;
  localparam logic [CNT_W-1:0] TERM = CNT_W'(DWELL - 1);

  logic [CNT_W-1:0] dwellCnt;
  logic             phaseHigh;
  logic             atTerm;

  assign atTerm = (dwellCnt == TERM);

  always_ff @(posedge clk) begin
    if (rst) begin
      dwellCnt  <= '0;
      phaseHigh <= 1'b0;
    end else if (atTerm) begin
      dwellCnt  <= '0;
      phaseHigh <= ~phaseHigh;
    end else begin
      dwellCnt  <= dwellCnt + 1'b1;
    end
  end

  always_comb begin
    strb.tick     = atTerm;
    strb.nextHigh = ~phaseHigh;
  end

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    dwellCnt <= TERM);

  assert_phase_flip_R3: assert property (@(posedge clk) disable iff (rst)
    atTerm |=> phaseHigh != $past(phaseHigh));

endmodule

// File: rtl/twin_hex_dp.sv
module twin_hex_dp
  import twin_hex_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  scanStrobe_t strb,
  input  logic [7:0]  hexVal,
  output logic [6:0]  segOut,
  output logic        digitSel
);

  logic [3:0] pickNib;
  logic [6:0] nextSeg;

  always_comb begin
    pickNib = strb.nextHigh ? hexVal[7:4] : hexVal[3:0];
    nextSeg = hexToSeg(pickNib);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      segOut   <= '0;
      digitSel <= 1'b0;
    end else if (strb.tick) begin
      segOut   <= nextSeg;
      digitSel <= strb.nextHigh;
    end
  end

  assert_hold_between_swaps_R7: assert property (@(posedge clk) disable iff (rst)
    !strb.tick |=> $stable(segOut) && $stable(digitSel));

  assert_sel_toggles_R3: assert property (@(posedge clk) disable iff (rst)
    strb.tick |=> digitSel != $past(digitSel));

  assert_lit_after_swap_R5: assert property (@(posedge clk) disable iff (rst)
    strb.tick |=> segOut != 7'h00);

endmodule

// File: rtl/twin_hex_display.sv
module twin_hex_display
  import twin_hex_pkg::*;
#(
  parameter int CLK_HZ     = 25_000_000,
  parameter int REFRESH_HZ = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] hexVal,
  output logic [6:0] segOut,
  output logic       digitSel
);

  scanStrobe_t strb;

  twin_hex_ctrl #(
    .CLK_HZ    (CLK_HZ),
    .REFRESH_HZ(REFRESH_HZ)
  ) i_ctrl (
    .clk (clk),
    .rst (rst),
    .strb(strb)
  );

  twin_hex_dp i_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .hexVal  (hexVal),
    .segOut  (segOut),
    .digitSel(digitSel)
  );

  assert_blank_in_reset_R1: assert property (@(posedge clk)
    rst |=> segOut == 7'h00 && !digitSel);

endmodule

// File: tb/test_twin_hex_display.sv
module test_twin_hex_display;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 4000;
  localparam int REFRESH_HZ = 200;
  localparam int DWELL      = CLK_HZ / (2 * REFRESH_HZ);

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] hexVal = 8'h00;
  logic [6:0] segOut;
  logic       digitSel;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;
  logic expSel = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twin_hex_display #(
    .CLK_HZ    (CLK_HZ),
    .REFRESH_HZ(REFRESH_HZ)
  ) i_twin_hex_display (
    .clk     (clk),
    .rst     (rst),
    .hexVal  (hexVal),
    .segOut  (segOut),
    .digitSel(digitSel)
  );

  function automatic logic [6:0] refSeg(input logic [3:0] n);
    case (n)
      4'd0:  return 7'b0111111;
      4'd1:  return 7'b0000110;
      4'd2:  return 7'b1011011;
      4'd3:  return 7'b1001111;
      4'd4:  return 7'b1100110;
      4'd5:  return 7'b1101101;
      4'd6:  return 7'b1111101;
      4'd7:  return 7'b0000111;
      4'd8:  return 7'b1111111;
      4'd9:  return 7'b1101111;
      4'd10: return 7'b1110111;
      4'd11: return 7'b1111100;
      4'd12: return 7'b0111001;
      4'd13: return 7'b1011110;
      4'd14: return 7'b1111001;
      default: return 7'b1110001;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic nextSwap();
    edges(DWELL);
    expSel = ~expSel;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    edges(2);
    rst = 1'b0;
    expSel = 1'b0;
  endtask

  task automatic testResetBlank();
    hexVal = 8'hA5;
    doReset();
    check(segOut == 7'h00, "R1 seg", segOut, 0);
    check(digitSel == 1'b0, "R1 sel", digitSel, 0);
    edges(DWELL - 1);
    check(segOut == 7'h00 && digitSel == 1'b0, "R1 blank before swap", {digitSel, segOut}, 0);
    edges(1);
    expSel = 1'b1;
    check(digitSel == 1'b1, "R2 first swap sel", digitSel, 1);
    check(segOut == refSeg(4'hA), "R2 high nibble", segOut, refSeg(4'hA));
  endtask

  task automatic testAlternate();
    hexVal = 8'h3C;
    nextSwap();
    check(digitSel == expSel && !expSel, "R3 sel to 0", digitSel, expSel);
    check(segOut == refSeg(4'hC), "R4 low nibble", segOut, refSeg(4'hC));
    nextSwap();
    check(digitSel == expSel && expSel, "R3 sel to 1", digitSel, expSel);
    check(segOut == refSeg(4'h3), "R4 high nibble", segOut, refSeg(4'h3));
  endtask

  task automatic testDecode();
    for (int n = 0; n < 16; n++) begin
      hexVal = {n[3:0], n[3:0]};
      nextSwap();
      if (n < 10) check(segOut == refSeg(n[3:0]), "R5 digit", segOut, refSeg(n[3:0]));
      else        check(segOut == refSeg(n[3:0]), "R6 letter", segOut, refSeg(n[3:0]));
      check(digitSel == expSel, "R3 sel phase", digitSel, expSel);
    end
  endtask

  task automatic testHoldAndMidChange();
    logic [6:0] segHeld;
    logic       selHeld;
    bit         moved;
    hexVal = 8'h21;
    nextSwap();
    segHeld = segOut;
    selHeld = digitSel;
    moved   = 1'b0;
    for (int k = 0; k < DWELL - 1; k++) begin
      if (k == 3) hexVal = 8'hEF;
      edges(1);
      if (segOut != segHeld || digitSel != selHeld) moved = 1'b1;
    end
    check(!moved, "R7 stable between swaps", {digitSel, segOut}, {selHeld, segHeld});
    check(!moved, "R8 mid-period change ignored", segOut, segHeld);
    edges(1);
    expSel = ~expSel;
    check(segOut == refSeg(expSel ? 4'hE : 4'hF), "R8 new value at swap",
          segOut, refSeg(expSel ? 4'hE : 4'hF));
    check(digitSel == expSel, "R7 sel with seg", digitSel, expSel);
  endtask

  task automatic testMidReset();
    hexVal = 8'h96;
    nextSwap();
    edges(4);
    rst = 1'b1;
    edges(1);
    check(segOut == 7'h00 && digitSel == 1'b0, "R9 reset blanks", {digitSel, segOut}, 0);
    rst = 1'b0;
    expSel = 1'b0;
    edges(DWELL - 1);
    check(segOut == 7'h00, "R9 still blank", segOut, 0);
    edges(1);
    check(digitSel == 1'b1 && segOut == refSeg(4'h9), "R9 restart timing",
          {digitSel, segOut}, {1'b1, refSeg(4'h9)});
  endtask

  initial begin
    testResetBlank();
    testAlternate();
    testDecode();
    testHoldAndMidChange();
    testMidReset();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule